// File: doc/BRIEF.md
# Indirect Configuration Register File for a Two-Wire Bus Controller

This block holds the run-time settings of a two-wire serial bus controller behind a host interface with only two addresses. One address is a pointer. The other is a data window onto the internal register that the pointer selects. The stored values leave the block as parallel configuration outputs for the bus engine:

- the bus speed class,
- the clock low and clock high counts,
- a timeout value,
- the controller's own bus address.

The block also contains a guarded software reset. With the pointer parked on a dedicated unlock slot, the host writes an arming byte and then a firing byte through the data window. The block then restores every register, the pointer included, to its default value. For that same edge it also raises a single-cycle reset pulse to the bus engine. After the pulse, the speed class and clock counts hold their defaults, so the host must write them again before the bus is used.

Reads have no side effects, and the pointer never advances by itself. A host driver therefore sets the pointer once and may then issue any number of reads or writes to the same register.

Top module: `i2c_cfg_regfile`

## Requirements
- R1: After reset the outputs take these values: own address 0x00, timeout 0xFF, clock low count 0x9D, clock high count 0x86, speed class 0. The pointer reads 0 and the reset pulse is low.
- R2: A write with `host_sel`=0 loads the low 3 bits of the write data into the pointer. A read with `host_sel`=0 returns the pointer zero-extended to 8 bits.
- R3: A write with `host_sel`=1 stores the data in the register selected by the pointer, using this index map: 0 own address, 1 timeout, 2 clock low count, 3 clock high count, 4 speed class, 5 unlock slot. The new value appears on the matching output after the capturing edge.
- R4: Indices 6 and 7 are unused. A data read returns 0x00 for them, and data writes to them change no register.
- R5: The speed class keeps only data bits 1:0 and reads back zero-extended. Its codes are 0 standard, 1 fast, 2 fast-plus and 3 turbo.
- R6: Reads change no state. Successive data accesses reach the same register until the pointer is written again.
- R7: A value written to the own-address register reads back unchanged after writes to other registers.
- R8: A data write of 0xA5 to the unlock slot arms the sequence. A data read of the unlock slot returns 0x01 while armed and 0x00 otherwise.
- R9: A data write of 0x5A to the unlock slot while armed triggers the reset. At the capturing edge every register, the pointer included, returns to its R1 value, and the reset output is high for the following cycle.
- R10: Only data writes to the unlock slot change the armed state. Any byte there other than 0xA5 or an armed 0x5A disarms without a reset. 0x5A while disarmed does nothing. 0xA5 while armed stays armed. Writes to other slots, and pointer writes, leave the armed state as it is.
- R11: The reset output is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | 0 selects the pointer, 1 selects the data window |
| host_wr | input | 1 | Write strobe, sampled at the rising edge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed port, combinational |
| cfg_mode | output | 2 | Bus speed class code |
| cfg_scl_low | output | 8 | Clock low count in oscillator periods |
| cfg_scl_high | output | 8 | Clock high count in oscillator periods |
| cfg_timeout | output | 8 | Timeout value |
| cfg_own_addr | output | 8 | Own bus address |
| ctl_reset_pulse | output | 1 | One-cycle reset request to the bus engine |

## Verification
A write takes effect at the rising edge that samples it. A stored value therefore appears on its output, and on the read port, from that edge onward. The bench drives every write half a period before the edge and compares the results at the following falling edge.

Read data passes straight from the pointer and the registers, with no register in the path. The bench checks a read during the same low phase in which it changes `host_sel`.

The reset pulse is a registered copy of the firing condition. It is expected high in exactly the one cycle after the edge that captures the firing byte, and low in the cycle after that. The defaults are checked in that same first cycle.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

  // Slot indices behind the pointer; the unlock slot position is behavioural.
  localparam int SLOT_OWN    = 0;
  localparam int SLOT_TMO    = 1;
  localparam int SLOT_LOW    = 2;
  localparam int SLOT_HIGH   = 3;
  localparam int SLOT_MODE   = 4;
  localparam int SLOT_UNLOCK = 5;
  localparam int NUM_FIELDS  = 5;

  // Speed class codes.
  localparam logic [1:0] MODE_STD   = 2'd0;
  localparam logic [1:0] MODE_FAST  = 2'd1;
  localparam logic [1:0] MODE_FASTP = 2'd2;
  localparam logic [1:0] MODE_TURBO = 2'd3;

endpackage

// File: rtl/cfgreg_rst_sync.sv
module cfgreg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/cfgreg_field.sv
module cfgreg_field #(
  parameter int         W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    q_en  = clr | we;
    q_nxt = clr ? RST_VAL : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL;
    else if (q_en) q <= q_nxt;
  end

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !clr) |=> $stable(q)); // R7

endmodule

// File: rtl/cfgreg_unlock.sv
module cfgreg_unlock #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] KEY_ARM  = 8'hA5,
  parameter logic [DATA_W-1:0] KEY_FIRE = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed,
  output logic              fire
);

  logic armed_nxt;

  always_comb begin
    fire      = slot_wr && armed && (wdata == KEY_FIRE);
    armed_nxt = (wdata == KEY_ARM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (slot_wr) armed <= armed_nxt;
  end

  AST_UNLOCK_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_wr |=> $stable(armed)); // R10

  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed); // R9

endmodule

// File: rtl/i2c_cfg_regfile.sv
module i2c_cfg_regfile
  import cfgreg_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                PTR_W     = 3,
  parameter int                MODE_W    = 2,
  parameter logic [DATA_W-1:0] DEF_OWN   = 8'h00,
  parameter logic [DATA_W-1:0] DEF_TMO   = 8'hFF,
  parameter logic [DATA_W-1:0] DEF_LOW   = 8'h9D,
  parameter logic [DATA_W-1:0] DEF_HIGH  = 8'h86,
  parameter logic [MODE_W-1:0] DEF_MODE  = MODE_STD,
  parameter logic [DATA_W-1:0] KEY_ARM   = 8'hA5,
  parameter logic [DATA_W-1:0] KEY_FIRE  = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [MODE_W-1:0] cfg_mode,
  output logic [DATA_W-1:0] cfg_scl_low,
  output logic [DATA_W-1:0] cfg_scl_high,
  output logic [DATA_W-1:0] cfg_timeout,
  output logic [DATA_W-1:0] cfg_own_addr,
  output logic              ctl_reset_pulse
);

  localparam int NUM_SLOTS = 1 << PTR_W;
  localparam logic [PTR_W-1:0] PTR_UNLOCK = PTR_W'(SLOT_UNLOCK);

  logic              rst_sync_n;
  logic [PTR_W-1:0]  ptr_q, ptr_nxt;
  logic              ptr_en;
  logic              data_wr, slot_wr;
  logic              armed, fire;
  logic              pulse_nxt;
  logic [DATA_W-1:0] fld_q [NUM_FIELDS];

  cfgreg_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Host write decode.
  always_comb begin
    data_wr = host_wr && host_sel;
    slot_wr = data_wr && (ptr_q == PTR_UNLOCK);
  end

  cfgreg_unlock #(
    .DATA_W   (DATA_W),
    .KEY_ARM  (KEY_ARM),
    .KEY_FIRE (KEY_FIRE)
  ) u_unlock (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .slot_wr (slot_wr),
    .wdata   (host_wdata),
    .armed   (armed),
    .fire    (fire)
  );

  // Pointer register: cleared by the unlock reset, never auto-increments.
  always_comb begin
    ptr_en  = fire || (host_wr && !host_sel);
    ptr_nxt = fire ? '0 : host_wdata[PTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_nxt;
  end

  // Configuration fields, one per slot below the unlock slot.
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam int W = (i == SLOT_MODE) ? MODE_W : DATA_W;
    localparam logic [DATA_W-1:0] RV_FULL =
      (i == SLOT_OWN)  ? DEF_OWN  :
      (i == SLOT_TMO)  ? DEF_TMO  :
      (i == SLOT_LOW)  ? DEF_LOW  :
      (i == SLOT_HIGH) ? DEF_HIGH : DATA_W'(DEF_MODE);
    localparam logic [W-1:0] RV = RV_FULL[W-1:0];

    logic         we;
    logic [W-1:0] q;

    assign we = data_wr && (ptr_q == PTR_W'(i));

    cfgreg_field #(
      .W       (W),
      .RST_VAL (RV)
    ) u_field (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (fire),
      .we    (we),
      .d     (host_wdata[W-1:0]),
      .q     (q)
    );

    assign fld_q[i] = DATA_W'(q);
  end

  // Read mux, free of side effects.
  always_comb begin
    host_rdata = '0;
    if (!host_sel) begin
      host_rdata[PTR_W-1:0] = ptr_q;
    end else begin
      for (int k = 0; k < NUM_SLOTS; k++) begin
        if (ptr_q == PTR_W'(k)) begin
          if (k < NUM_FIELDS)        host_rdata = fld_q[k];
          else if (k == SLOT_UNLOCK) host_rdata = DATA_W'(armed);
        end
      end
    end
  end

  // Reset request to the bus engine.
  assign pulse_nxt = fire;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctl_reset_pulse <= 1'b0;
    else             ctl_reset_pulse <= pulse_nxt;
  end

  always_comb begin
    cfg_own_addr = fld_q[SLOT_OWN];
    cfg_timeout  = fld_q[SLOT_TMO];
    cfg_scl_low  = fld_q[SLOT_LOW];
    cfg_scl_high = fld_q[SLOT_HIGH];
    cfg_mode     = fld_q[SLOT_MODE][MODE_W-1:0];
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctl_reset_pulse |=> !ctl_reset_pulse); // R11

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctl_reset_pulse |-> $past(host_wr && host_sel && host_wdata == KEY_FIRE
                              && ptr_q == PTR_UNLOCK)); // R9

  AST_DEFAULTS_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctl_reset_pulse |-> (ptr_q == '0 && cfg_mode == DEF_MODE && cfg_scl_low == DEF_LOW
                         && cfg_scl_high == DEF_HIGH && cfg_timeout == DEF_TMO
                         && cfg_own_addr == DEF_OWN)); // R9

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(host_wr && !host_sel) && !fire) |=> $stable(ptr_q)); // R6

endmodule

// File: tb/tb_i2c_cfg_regfile.sv
module tb_i2c_cfg_regfile;

  localparam int CLK_P = 10;
  localparam int WD_CYCLES = 5000;
  localparam int NV = 41;

  // Vector: [21] 1=read check, [20] sel, [19:12] write data, [11:4] expected, [3:0] requirement
  localparam logic [21:0] VEC [NV] = '{
    {1'b1,1'b0,8'h00,8'h00,4'd1},   // R1 pointer reset
    {1'b1,1'b1,8'h00,8'h00,4'd1},   // R1 own address default
    {1'b0,1'b0,8'h01,8'h00,4'd2},
    {1'b1,1'b1,8'h00,8'hFF,4'd1},   // R1 timeout default
    {1'b0,1'b0,8'h00,8'h00,4'd2},
    {1'b0,1'b1,8'h3C,8'h00,4'd3},
    {1'b1,1'b1,8'h00,8'h3C,4'd3},   // R3
    {1'b0,1'b0,8'h04,8'h00,4'd2},
    {1'b0,1'b1,8'hFF,8'h00,4'd5},
    {1'b1,1'b1,8'h00,8'h03,4'd5},   // R5 mode truncated
    {1'b1,1'b0,8'h00,8'h04,4'd2},   // R2
    {1'b0,1'b1,8'h02,8'h00,4'd5},
    {1'b1,1'b1,8'h00,8'h02,4'd5},   // R5
    {1'b0,1'b0,8'h02,8'h00,4'd2},
    {1'b0,1'b1,8'h11,8'h00,4'd6},
    {1'b0,1'b1,8'h22,8'h00,4'd6},
    {1'b1,1'b1,8'h00,8'h22,4'd6},   // R6 same slot
    {1'b1,1'b0,8'h00,8'h02,4'd6},   // R6 no increment
    {1'b0,1'b0,8'h03,8'h00,4'd2},
    {1'b0,1'b1,8'h44,8'h00,4'd3},
    {1'b1,1'b1,8'h00,8'h44,4'd3},   // R3
    {1'b0,1'b0,8'h00,8'h00,4'd2},
    {1'b1,1'b1,8'h00,8'h3C,4'd7},   // R7
    {1'b1,1'b1,8'h00,8'h3C,4'd6},   // R6 read no side effect
    {1'b0,1'b0,8'h06,8'h00,4'd2},
    {1'b0,1'b1,8'h77,8'h00,4'd4},
    {1'b1,1'b1,8'h00,8'h00,4'd4},   // R4
    {1'b0,1'b0,8'h07,8'h00,4'd2},
    {1'b0,1'b1,8'h99,8'h00,4'd4},
    {1'b1,1'b1,8'h00,8'h00,4'd4},   // R4
    {1'b0,1'b0,8'h0D,8'h00,4'd2},
    {1'b1,1'b0,8'h00,8'h05,4'd2},   // R2 pointer truncated
    {1'b1,1'b1,8'h00,8'h00,4'd8},   // R8 disarmed
    {1'b0,1'b1,8'hA5,8'h00,4'd8},
    {1'b1,1'b1,8'h00,8'h01,4'd8},   // R8 armed
    {1'b0,1'b1,8'h33,8'h00,4'd10},
    {1'b1,1'b1,8'h00,8'h00,4'd10},  // R10 disarmed by wrong byte
    {1'b0,1'b1,8'h5A,8'h00,4'd10},
    {1'b1,1'b1,8'h00,8'h00,4'd10},  // R10 fire byte while disarmed
    {1'b0,1'b0,8'h00,8'h00,4'd2},
    {1'b1,1'b1,8'h00,8'h3C,4'd10}   // R10 no reset happened
  };

  logic       clk, rst_n, host_sel, host_wr;
  logic [7:0] host_wdata, host_rdata, cfg_scl_low, cfg_scl_high, cfg_timeout, cfg_own_addr;
  logic [1:0] cfg_mode;
  logic       ctl_reset_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int n_pulse = 0;
  bit done = 0;

  i2c_cfg_regfile dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_sel        (host_sel),
    .host_wr         (host_wr),
    .host_wdata      (host_wdata),
    .host_rdata      (host_rdata),
    .cfg_mode        (cfg_mode),
    .cfg_scl_low     (cfg_scl_low),
    .cfg_scl_high    (cfg_scl_high),
    .cfg_timeout     (cfg_timeout),
    .cfg_own_addr    (cfg_own_addr),
    .ctl_reset_pulse (ctl_reset_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) if (rst_n && ctl_reset_pulse) n_pulse++;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  // Called in the low phase; returns in the next low phase.
  task automatic wr(input logic sel, input logic [7:0] d);
    host_sel = sel; host_wr = 1'b1; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic sel, input logic [7:0] exp);
    host_sel = sel;
    #1;
    check(req, host_rdata, exp);
    @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset outputs
    check("R1", {6'd0, cfg_mode}, 8'h00);
    check("R1", cfg_scl_low, 8'h9D);
    check("R1", cfg_scl_high, 8'h86);
    check("R1", cfg_timeout, 8'hFF);
    check("R1", cfg_own_addr, 8'h00);
    check("R1", {7'd0, ctl_reset_pulse}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[v][3:0]);
      if (VEC[v][21]) rd(rq, VEC[v][20], VEC[v][11:4]);
      else            wr(VEC[v][20], VEC[v][19:12]);
    end
    check("R10", 8'(n_pulse), 8'h00);

    // R3 and R5 outputs carry stored values
    check("R3", cfg_own_addr, 8'h3C);
    check("R3", cfg_timeout, 8'hFF);
    check("R3", cfg_scl_low, 8'h22);
    check("R3", cfg_scl_high, 8'h44);
    check("R5", {6'd0, cfg_mode}, 8'h02);

    // R10 re-arm holds, other-slot writes keep armed state
    wr(1'b0, 8'h05);
    wr(1'b1, 8'hA5);
    wr(1'b1, 8'hA5);
    rd("R10", 1'b1, 8'h01);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h5A);
    check("R10", cfg_own_addr, 8'h5A);
    check("R10", 8'(n_pulse), 8'h00);
    wr(1'b0, 8'h05);
    rd("R10", 1'b1, 8'h01);

    // R9 firing write
    host_sel = 1'b1; host_wr = 1'b1; host_wdata = 8'h5A;
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0;
    check("R9", {7'd0, ctl_reset_pulse}, 8'h01);
    check("R9", cfg_own_addr, 8'h00);
    check("R9", cfg_scl_low, 8'h9D);
    check("R9", cfg_scl_high, 8'h86);
    check("R9", cfg_timeout, 8'hFF);
    check("R9", {6'd0, cfg_mode}, 8'h00);
    host_sel = 1'b0;
    #1;
    check("R9", host_rdata, 8'h00);
    @(negedge clk);
    check("R11", {7'd0, ctl_reset_pulse}, 8'h00);
    check("R11", 8'(n_pulse), 8'h01);
    rd("R9", 1'b1, 8'h00);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule